// File: doc/BRIEF.md
# DAC Serial Front End

This block is the digital front end of a single-channel digital-to-analog converter. A host shifts 24-bit frames into it over a three-wire serial port: a serial clock, a data line, and a frame strobe. Each frame is sent most significant bit first. The upper byte is an address and the lower 16 bits are the payload. On each rising edge of the frame strobe, the block decodes the frame that was just shifted in. The frame can do one of four things:

- write the output code register;
- write the control register;
- arm a readback;
- reset all registers.

The block drives a 16-bit output code bus and an output-enable flag.

A serial output serves two purposes. After a readback request, it returns 8 zero bits and then the selected 16-bit register during the following frame. In daisy-chain mode, it repeats each bit 24 serial clocks after it entered, so several parts can share one strobe.

An asynchronous clear input forces the code bus to a clear value for as long as it is held. The clear value is zero for current ranges. For voltage ranges, it is zero-scale or midscale, chosen by a select pin. All serial inputs are brought into the single system clock domain through two-flop synchronisers.

Top module: `dac_serial_front`

## Requirements
- R1: Frames are 24 bits, sampled on rising serial clock edges, MSB first. On a rising strobe edge, frame bits 23:16 are the address and bits 15:0 the payload. Address 0x01 writes the payload to the code register.
- R2: Address 0x55 writes the control register from payload bits. Bits 2:0 are the output range, bit 3 is output enable, bit 4 is daisy-chain enable and bit 5 is overrange enable. out_en_o follows bit 3.
- R3: While output enable is 0, code_o equals the clear value, and any code written is held until enable is set.
- R4: While clear_i is 1, code_o equals the clear value regardless of the stored code. When clear_i returns to 0, code_o shows the stored code again. The stored code is not altered.
- R5: The clear value is 0x0000 when the range field is 5, 6 or 7 (current ranges). For ranges 0 to 4 (voltage ranges), it is 0x8000 when clear_sel_i is 1 and 0x0000 when clear_sel_i is 0.
- R6: Address 0x02 arms a readback. Payload bit 0 selects the register: 0 for the code register, 1 for the control register, zero-extended to 16 bits. During the next frame, sdo_oe_o is 1 and sdo_o shows 8 zero bits, then the 16 register bits MSB first. Each bit is valid before the serial clock rise that shifts it. After the next strobe, sdo_oe_o returns to 0.
- R7: With daisy-chain enabled, sdo_oe_o is 1 and sdo_o presents, before each serial clock rise, the bit shifted in 24 rises earlier.
- R8: Address 0x56 returns every register to its power-on default: code 0, control 0, readback idle.
- R9: After rst_ni, code_o is 0x0000, out_en_o is 0, and sdo_oe_o and sdo_o are 0.
- R10: With RES_BITS = 12, the stored code keeps payload bits 15:4 and bits 3:0 read as 0.
- R11: Frames with address 0x00 or any address not listed above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdin_i | input | 1 | Serial data in |
| latch_i | input | 1 | Frame strobe, rising edge decodes |
| clear_i | input | 1 | Asynchronous clear, active high |
| clear_sel_i | input | 1 | Voltage clear value: 1 midscale, 0 zero-scale |
| code_o | output | 16 | Output code bus |
| out_en_o | output | 1 | Output enable |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial out drive enable |

## Verification
The bench builds two instances on the same serial, strobe and clear stimulus. One uses RES_BITS = 16 and the other RES_BITS = 12, both with a 24-bit frame and two synchroniser stages. Driving both from the same stimulus makes the 12-bit left-alignment directly comparable with the full-resolution code in every random frame. Random frames mix code writes, control writes, no-ops and unknown addresses with random clear and clear-select levels. Directed frames cover readback of both registers, daisy-chain pass-through, and the reset command.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam logic [7:0] ADDR_NOP  = 8'h00;
  localparam logic [7:0] ADDR_CODE = 8'h01;
  localparam logic [7:0] ADDR_RB   = 8'h02;
  localparam logic [7:0] ADDR_CTRL = 8'h55;
  localparam logic [7:0] ADDR_RST  = 8'h56;

  typedef struct packed {
    logic       ovr;
    logic       daisy;
    logic       out_en;
    logic [2:0] range;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic range_is_current(input logic [2:0] r);
    return r >= 3'd5;
  endfunction
endpackage

// File: rtl/dac_sync_edge.sv
module dac_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dac_shift_port.sv
module dac_shift_port #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               sdin_i,
  input  logic               rb_load_i,
  input  logic [FRAME_W-1:0] rb_word_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               rb_bit_o
);
  logic [FRAME_W-1:0] shift_q;
  logic [FRAME_W-1:0] rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else if (sclk_rise_i) begin
      shift_q <= {shift_q[FRAME_W-2:0], sdin_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q <= '0;
    end else if (rb_load_i) begin
      rb_q <= rb_word_i;
    end else if (sclk_rise_i) begin
      rb_q <= {rb_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign frame_o  = shift_q;
  assign rb_bit_o = rb_q[FRAME_W-1];

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_i |=> shift_q[0] == $past(sdin_i));
endmodule

// File: rtl/dac_reg_file.sv
module dac_reg_file
  import dac_fe_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int DATA_W   = 16,
  parameter int RES_BITS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_rise_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [DATA_W-1:0]  code_q_o,
  output ctrl_t              ctrl_o,
  output logic               rb_load_o,
  output logic [FRAME_W-1:0] rb_word_o,
  output logic               rb_active_o
);
  localparam int ADDR_W = FRAME_W - DATA_W;
  localparam int PAD    = DATA_W - RES_BITS;
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((64'd1 << PAD) - 64'd1);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] payload;
  logic [DATA_W-1:0] code_q;
  ctrl_t             ctrl_q;
  logic              rb_q;
  logic [DATA_W-1:0] rb_val;

  assign addr    = frame_i[FRAME_W-1 -: ADDR_W];
  assign payload = frame_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      ctrl_q <= '0;
      rb_q   <= 1'b0;
    end else if (latch_rise_i) begin
      rb_q <= (addr == ADDR_W'(ADDR_RB));
      unique case (addr)
        ADDR_W'(ADDR_CODE): code_q <= payload & ~LOW_MASK;
        ADDR_W'(ADDR_CTRL): ctrl_q <= ctrl_t'(payload[CTRL_W-1:0]);
        ADDR_W'(ADDR_RST): begin
          code_q <= '0;
          ctrl_q <= '0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rb_val    = payload[0] ? DATA_W'(ctrl_q) : code_q;
    rb_word_o = {{ADDR_W{1'b0}}, rb_val};
    rb_load_o = latch_rise_i && (addr == ADDR_W'(ADDR_RB));
  end

  assign code_q_o    = code_q;
  assign ctrl_o      = ctrl_q;
  assign rb_active_o = rb_q;

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_rise_i && addr != ADDR_W'(ADDR_CODE) && addr != ADDR_W'(ADDR_RST)) |=> $stable(code_q));
  assert_reset_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_rise_i && addr == ADDR_W'(ADDR_RST)) |=> (code_q == '0 && ctrl_q == '0 && !rb_q));
  assert_rb_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_rise_i && addr == ADDR_W'(ADDR_RB)) |=> rb_q);
  assert_res_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_rise_i |=> (code_q & LOW_MASK) == '0);
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_fe_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int DATA_W   = 16,
  parameter int RES_BITS = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              latch_i,
  input  logic              clear_i,
  input  logic              clear_sel_i,
  output logic [DATA_W-1:0] code_o,
  output logic              out_en_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int N_SYNC = 3;
  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [N_SYNC-1:0] async_in, sync_lvl, sync_rise;
  assign async_in = {latch_i, sdin_i, sclk_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    dac_sync_edge #(.STAGES(SYNC_STG)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (async_in[g]),
      .lvl_o (sync_lvl[g]),
      .rise_o(sync_rise[g])
    );
  end

  logic               sclk_rise, sdin_s, latch_rise;
  logic [FRAME_W-1:0] frame, rb_word;
  logic               rb_load, rb_bit, rb_active;
  logic [DATA_W-1:0]  code_q, clear_val;
  ctrl_t              ctrl;
  logic               cur_mode;

  assign sclk_rise  = sync_rise[0];
  assign sdin_s     = sync_lvl[1];
  assign latch_rise = sync_rise[2];

  dac_shift_port #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .sdin_i     (sdin_s),
    .rb_load_i  (rb_load),
    .rb_word_i  (rb_word),
    .frame_o    (frame),
    .rb_bit_o   (rb_bit)
  );

  dac_reg_file #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .RES_BITS(RES_BITS)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_rise_i(latch_rise),
    .frame_i     (frame),
    .code_q_o    (code_q),
    .ctrl_o      (ctrl),
    .rb_load_o   (rb_load),
    .rb_word_o   (rb_word),
    .rb_active_o (rb_active)
  );

  // clear path is combinational from the pin: no clock needed
  always_comb begin
    cur_mode  = range_is_current(ctrl.range);
    clear_val = (cur_mode || !clear_sel_i) ? '0 : MID_CODE;
    code_o    = (clear_i || !ctrl.out_en) ? clear_val : code_q;
  end

  assign out_en_o = ctrl.out_en;
  assign sdo_oe_o = rb_active | ctrl.daisy;
  assign sdo_o    = rb_active ? rb_bit : (ctrl.daisy ? frame[FRAME_W-1] : 1'b0);

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && (cur_mode || !clear_sel_i)) |-> code_o == '0);
  assert_sdo_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
  assert_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_o && !clear_sel_i) |-> code_o == '0);
endmodule

// File: tb/test_dac_serial_front.sv
module test_dac_serial_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, latch = 1'b0, clr = 1'b0, clr_sel = 1'b0;
  logic [15:0] code16, code12;
  logic en16, en12, sdo16, sdo12, oe16, oe12;
  int errors = 0, checks = 0;
  logic [15:0] m_code = '0;
  logic [5:0]  m_ctrl = '0;
  logic        finished = 1'b0;

  always #10 clk = ~clk;

  dac_serial_front i_dac_serial_front (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin), .latch_i(latch),
    .clear_i(clr), .clear_sel_i(clr_sel), .code_o(code16), .out_en_o(en16),
    .sdo_o(sdo16), .sdo_oe_o(oe16));

  dac_serial_front #(.RES_BITS(12)) i_dac_serial_front_r12 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin), .latch_i(latch),
    .clear_i(clr), .clear_sel_i(clr_sel), .code_o(code12), .out_en_o(en12),
    .sdo_o(sdo12), .sdo_oe_o(oe12));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_code(input logic [15:0] d, input logic [5:0] c,
                                           input logic cl, input logic sel, input int res);
    logic [15:0] cv, dm;
    cv = ((c[2:0] >= 3'd5) || !sel) ? 16'h0000 : 16'h8000;
    dm = (res == 12) ? (d & 16'hFFF0) : d;
    return (cl || !c[3]) ? cv : dm;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, output logic [23:0] cap);
    for (int i = 23; i >= 0; i--) begin
      sdin = w[i];
      wait_clk(4);
      cap[i] = sdo16;
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
  endtask

  task automatic strobe();
    latch = 1'b1;
    wait_clk(6);
    latch = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame(input logic [7:0] a, input logic [15:0] p);
    logic [23:0] cap;
    send({a, p}, cap);
    strobe();
    if (a == 8'h01) m_code = p;
    else if (a == 8'h55) m_ctrl = p[5:0];
    else if (a == 8'h56) begin m_code = '0; m_ctrl = '0; end
  endtask

  task automatic check_codes(input string req);
    check(req, {16'h0, code16}, {16'h0, exp_code(m_code, m_ctrl, clr, clr_sel, 16)});
    check({req, "_r12"}, {16'h0, code12}, {16'h0, exp_code(m_code, m_ctrl, clr, clr_sel, 12)});
  endtask

  task automatic readback(input logic sel, input logic [15:0] exp, input string req);
    logic [23:0] cap;
    frame(8'h02, {15'h0, sel});
    check({req, "_oe"}, {31'h0, oe16}, 32'h1);
    send(24'h000000, cap);
    check(req, {8'h0, cap}, {8'h0, 8'h00, exp});
    strobe();
    check({req, "_idle"}, {31'h0, oe16}, 32'h0);
  endtask

  initial begin
    logic [23:0] cap;
    void'($urandom(32'h5EED_0042));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R9 reset state
    check("R9_code", {16'h0, code16}, 32'h0);
    check("R9_en", {31'h0, en16}, 32'h0);
    check("R9_oe", {30'h0, oe16, sdo16}, 32'h0);

    // R3 code held while disabled
    frame(8'h01, 16'h1234);
    check("R3_held", {16'h0, code16}, 32'h0);
    // R1 R2 enable, voltage range 0
    frame(8'h55, 16'h0008);
    check("R2_en", {31'h0, en16}, 32'h1);
    check_codes("R1_code");
    check("R10_r12", {16'h0, code12}, 32'h1230);
    // R4 R5 clear
    clr_sel = 1'b1; clr = 1'b1; wait_clk(1);
    check("R5_mid", {16'h0, code16}, 32'h8000);
    clr_sel = 1'b0; wait_clk(1);
    check("R4_zero", {16'h0, code16}, 32'h0);
    clr = 1'b0; wait_clk(1);
    check("R4_release", {16'h0, code16}, 32'h1234);
    frame(8'h55, 16'h000D);
    clr_sel = 1'b1; clr = 1'b1; wait_clk(1);
    check("R5_current", {16'h0, code16}, 32'h0);
    clr = 1'b0; clr_sel = 1'b0; wait_clk(1);
    // R6 readback both registers, overrange visible
    frame(8'h55, 16'h0029);
    readback(1'b0, 16'h1234, "R6_code");
    readback(1'b1, 16'h0029, "R6_ctrl");
    // R11 no-op and unknown address
    frame(8'h00, 16'hFFFF);
    frame(8'h33, 16'hFFFF);
    check_codes("R11_code");
    readback(1'b1, 16'h0029, "R11_ctrl");
    // R7 daisy chain
    frame(8'h55, 16'h0018);
    check("R7_oe", {31'h0, oe16}, 32'h1);
    send(24'hA5C3_96, cap);
    send(24'h00_BEEF, cap);
    check("R7_pass", {8'h0, cap}, {8'h0, 24'hA5C396});
    strobe();
    frame(8'h55, 16'h0008);
    // R8 reset command
    frame(8'h56, 16'h0000);
    check("R8_en", {31'h0, en16}, 32'h0);
    check_codes("R8_code");
    readback(1'b0, 16'h0000, "R8_rb");

    // random phase
    for (int it = 0; it < 60; it++) begin
      int sel;
      logic [15:0] p;
      sel = $urandom % 4;
      p = 16'($urandom);
      case (sel)
        0: frame(8'h01, p);
        1: frame(8'h55, p & 16'h002F);
        2: frame(8'h00, p);
        default: frame(8'h10 + 8'($urandom % 16), p);
      endcase
      clr = 1'($urandom); clr_sel = 1'($urandom);
      wait_clk(1);
      check_codes("R1_R4_R5_rand");
      clr = 1'b0;
      wait_clk(1);
    end
    readback(1'b0, m_code, "R6_rand");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule